// File: doc/BRIEF.md
# Register File with Pointer Pairs

This block stores the working registers of a small 8-bit processor core: thirty-two bytes with two combinational read ports and one byte write port that commits on the clock edge. The six highest registers also form three 16-bit pointers. A separate pointer interface reads any one pair as a single word. It can also rewrite a whole pair in one edge, either with a fresh value or with the current value plus or minus one. This serves address post-increment and pre-decrement.

Decode, arithmetic and memory live elsewhere. The core presents register indices and write strobes each cycle and takes the read data back in the same cycle. The interfaces are plain control and data pins with no handshake, because every access completes within one cycle and can never be stalled.

Top module: `ptr_regfile`

## Requirements
- R1: An active-low asynchronous reset clears all 32 registers to zero, so both read ports and the pointer read port return 0 after reset.
- R2: Two read ports return the register named by their own 5-bit index combinationally and independently of each other.
- R3: With `wr_en` high, `wr_data` is stored into register `wr_idx` on the rising edge and every other register keeps its value.
- R4: A read during a write cycle returns the value held before that edge. There is no write-through to the read ports or the pointer read port.
- R5: Pointer select code 1 reads {R27,R26}, code 2 reads {R29,R28} and code 3 reads {R31,R30}, with the odd register as the high byte. Code 0 reads 16'h0000.
- R6: Pointer write op 1 (load) stores `ptr_wr_data` into the selected pair, updating both bytes on the same edge.
- R7: Op 2 stores the pair's current value plus one and op 3 stores it minus one. Both wrap modulo 2^16, and the carry or borrow crosses from the low byte to the high byte.
- R8: Pointer select 0 or op 0 leaves every register unchanged, whatever `ptr_wr_data` holds. With `wr_en` low as well, no register changes.
- R9: When the byte write targets a register of the pair being written by the pointer port in the same cycle, the pointer result is stored. A byte write to any other register in that cycle still takes effect.
- R10: Byte writes to R26..R31 are seen through the pointer read port, and pointer writes are seen through the byte read ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 5 | Read port A register index |
| rd_a_data | output | 8 | Read port A data |
| rd_b_idx | input | 5 | Read port B register index |
| rd_b_data | output | 8 | Read port B data |
| wr_en | input | 1 | Byte write strobe |
| wr_idx | input | 5 | Byte write register index |
| wr_data | input | 8 | Byte write data |
| ptr_rd_sel | input | 2 | Pointer read select (0 none, 1..3 pair) |
| ptr_rd_data | output | 16 | Pointer read word |
| ptr_wr_sel | input | 2 | Pointer write select (0 none, 1..3 pair) |
| ptr_wr_op | input | 2 | Pointer write op: 0 none, 1 load, 2 increment, 3 decrement |
| ptr_wr_data | input | 16 | Pointer load value |

## Verification
The bench targets carry and borrow across the byte boundary of each pair: 00FF to 0100 on increment, FFFF to 0000, 0000 to FFFF and 0100 to 00FF. A design that adjusted the bytes separately would lose the carry or leave the high byte stale. It collides byte writes with pointer writes on the same pair, where a wrong priority leaves the byte value in place of the pointer result. It also pairs them on unrelated registers, where a blocking priority would drop the byte write. Reads are taken during write cycles to catch a write-through bypass. Pointer writes with a zero select or zero op carry nonzero data, so a decoder that ignores either field corrupts a pair.

// File: rtl/rf_pkg.sv
package rf_pkg;
  typedef enum logic [1:0] {
    PSEL_NONE = 2'd0,
    PSEL_X    = 2'd1,
    PSEL_Y    = 2'd2,
    PSEL_Z    = 2'd3
  } psel_e;

  typedef enum logic [1:0] {
    POP_NONE = 2'd0,
    POP_LOAD = 2'd1,
    POP_INC  = 2'd2,
    POP_DEC  = 2'd3
  } pop_e;
endpackage

// File: rtl/rf_ptr_map.sv
// Maps a pointer select code onto the even (low-byte) register index of its pair.
module rf_ptr_map #(
  parameter int NUM_REGS = 32,
  parameter int IDX_W    = 5
) (
  input  logic [1:0]       sel,
  output logic             hit,
  output logic [IDX_W-1:0] lo_idx
);
  import rf_pkg::*;
  // Pairs occupy the top six registers; code 1 starts at NUM_REGS-6.
  localparam int FIRST_LO = NUM_REGS - 8;

  always_comb begin
    hit    = (psel_e'(sel) != PSEL_NONE);
    lo_idx = IDX_W'(FIRST_LO + 2 * int'(sel));
  end
endmodule

// File: rtl/rf_ptr_adjust.sv
// Computes the next pointer value for load, increment or decrement.
module rf_ptr_adjust #(
  parameter int PTR_W = 16
) (
  input  logic [PTR_W-1:0] cur,
  input  logic [1:0]       op,
  input  logic [PTR_W-1:0] load_val,
  output logic             en,
  output logic [PTR_W-1:0] nxt
);
  import rf_pkg::*;

  always_comb begin
    en  = 1'b1;
    nxt = cur;
    unique case (pop_e'(op))
      POP_LOAD: nxt = load_val;
      POP_INC:  nxt = cur + PTR_W'(1);
      POP_DEC:  nxt = cur - PTR_W'(1);
      default:  en  = 1'b0;
    endcase
  end
endmodule

// File: rtl/rf_bank.sv
// Register storage; a pair write takes priority over a byte write to the same register.
module rf_bank #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 8,
  parameter int IDX_W    = 5
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               byte_en,
  input  logic [IDX_W-1:0]                   byte_idx,
  input  logic [DATA_W-1:0]                  byte_data,
  input  logic                               pair_en,
  input  logic [IDX_W-1:0]                   pair_lo,
  input  logic [2*DATA_W-1:0]                pair_data,
  output logic [NUM_REGS-1:0][DATA_W-1:0]    regs
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [IDX_W-1:0] GI = IDX_W'(g);
    logic pair_hit;
    logic byte_hit;
    logic [DATA_W-1:0] pair_byte;

    always_comb begin
      pair_hit  = pair_en && (pair_lo[IDX_W-1:1] == GI[IDX_W-1:1]);
      byte_hit  = byte_en && (byte_idx == GI);
      pair_byte = GI[0] ? pair_data[2*DATA_W-1:DATA_W] : pair_data[DATA_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs[g] <= '0;
      end else if (pair_hit) begin
        regs[g] <= pair_byte;
      end else if (byte_hit) begin
        regs[g] <= byte_data;
      end
    end
  end
endmodule

// File: rtl/ptr_regfile.sv
module ptr_regfile #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 8,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int PTR_W   = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        ptr_rd_sel,
  output logic [PTR_W-1:0]  ptr_rd_data,
  input  logic [1:0]        ptr_wr_sel,
  input  logic [1:0]        ptr_wr_op,
  input  logic [PTR_W-1:0]  ptr_wr_data
);
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;

  logic             rd_hit;
  logic [IDX_W-1:0] rd_lo;
  logic             wr_hit;
  logic [IDX_W-1:0] wr_lo;
  logic [PTR_W-1:0] wr_cur;
  logic [PTR_W-1:0] wr_nxt;
  logic             op_en;

  rf_ptr_map #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_rd_map (
    .sel(ptr_rd_sel), .hit(rd_hit), .lo_idx(rd_lo)
  );

  rf_ptr_map #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_wr_map (
    .sel(ptr_wr_sel), .hit(wr_hit), .lo_idx(wr_lo)
  );

  assign wr_cur = {regs[{wr_lo[IDX_W-1:1], 1'b1}], regs[wr_lo]};

  rf_ptr_adjust #(.PTR_W(PTR_W)) u_adjust (
    .cur(wr_cur), .op(ptr_wr_op), .load_val(ptr_wr_data),
    .en(op_en), .nxt(wr_nxt)
  );

  rf_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .byte_en(wr_en), .byte_idx(wr_idx), .byte_data(wr_data),
    .pair_en(wr_hit && op_en), .pair_lo(wr_lo), .pair_data(wr_nxt),
    .regs(regs)
  );

  always_comb begin
    rd_a_data   = regs[rd_a_idx];
    rd_b_data   = regs[rd_b_idx];
    ptr_rd_data = rd_hit ? {regs[{rd_lo[IDX_W-1:1], 1'b1}], regs[rd_lo]} : '0;
  end
endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 8,
  parameter int IDX_W    = 5
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            wr_en,
  input logic [IDX_W-1:0]                wr_idx,
  input logic [DATA_W-1:0]               wr_data,
  input logic [1:0]                      ptr_rd_sel,
  input logic [2*DATA_W-1:0]             ptr_rd_data,
  input logic [1:0]                      ptr_wr_sel,
  input logic [1:0]                      ptr_wr_op,
  input logic [2*DATA_W-1:0]             ptr_wr_data,
  input logic [NUM_REGS-1:0][DATA_W-1:0] regs
);
  localparam int PW = 2 * DATA_W;

  logic [IDX_W-1:0] w_lo, r_lo;
  logic             p_act;
  logic [PW-1:0]    p_cur, p_exp;

  logic             pv_q, bv_q;
  logic [IDX_W-1:0] plo_q, bidx_q;
  logic [PW-1:0]    pexp_q;
  logic [DATA_W-1:0] bdata_q;

  always_comb begin
    w_lo  = IDX_W'(NUM_REGS - 8 + 2 * int'(ptr_wr_sel));
    r_lo  = IDX_W'(NUM_REGS - 8 + 2 * int'(ptr_rd_sel));
    p_act = (ptr_wr_sel != 2'd0) && (ptr_wr_op != 2'd0);
    p_cur = {regs[{w_lo[IDX_W-1:1], 1'b1}], regs[w_lo]};
    case (ptr_wr_op)
      2'd1:    p_exp = ptr_wr_data;
      2'd2:    p_exp = p_cur + PW'(1);
      default: p_exp = p_cur - PW'(1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv_q    <= 1'b0;
      bv_q    <= 1'b0;
      plo_q   <= '0;
      bidx_q  <= '0;
      pexp_q  <= '0;
      bdata_q <= '0;
    end else begin
      pv_q    <= p_act;
      plo_q   <= w_lo;
      pexp_q  <= p_exp;
      bv_q    <= wr_en && !(p_act && (wr_idx[IDX_W-1:1] == w_lo[IDX_W-1:1]));
      bidx_q  <= wr_idx;
      bdata_q <= wr_data;
    end
  end

  assert_byte_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bv_q |-> regs[bidx_q] == bdata_q);

  // Covers R7 (wrap) and R9 (pointer wins) as well.
  assert_ptr_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pv_q |-> {regs[{plo_q[IDX_W-1:1], 1'b1}], regs[plo_q]} == pexp_q);

  assert_ptr_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_rd_sel != 2'd0) |-> ptr_rd_data == {regs[{r_lo[IDX_W-1:1], 1'b1}], regs[r_lo]});

  assert_ptr_read_none_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_rd_sel == 2'd0) |-> ptr_rd_data == '0);

  assert_idle_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !p_act) |=> $stable(regs));
endmodule

bind ptr_regfile rf_checker #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_rf_checker (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
  .ptr_rd_sel(ptr_rd_sel), .ptr_rd_data(ptr_rd_data),
  .ptr_wr_sel(ptr_wr_sel), .ptr_wr_op(ptr_wr_op), .ptr_wr_data(ptr_wr_data),
  .regs(regs)
);

// File: tb/test_ptr_regfile.sv
`timescale 1ns/1ps
module test_ptr_regfile;
  localparam int NR = 32;
  localparam int DW = 8;
  localparam int IW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [IW-1:0] rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [DW-1:0] rd_a_data, rd_b_data, wr_data = '0;
  logic          wr_en = 1'b0;
  logic [1:0]    ptr_rd_sel = '0, ptr_wr_sel = '0, ptr_wr_op = '0;
  logic [15:0]   ptr_rd_data, ptr_wr_data = '0;

  ptr_regfile #(.NUM_REGS(NR), .DATA_W(DW)) i_ptr_regfile (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .ptr_rd_sel(ptr_rd_sel), .ptr_rd_data(ptr_rd_data),
    .ptr_wr_sel(ptr_wr_sel), .ptr_wr_op(ptr_wr_op), .ptr_wr_data(ptr_wr_data)
  );

  always #2 clk = ~clk;

  logic [DW-1:0] mdl [NR];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] mdl_ptr(input int sel);
    int lo;
    if (sel == 0) return 16'h0000;
    lo = NR - 8 + 2 * sel;
    return {mdl[lo+1], mdl[lo]};
  endfunction

  task automatic idle();
    wr_en = 1'b0; wr_idx = '0; wr_data = '0;
    ptr_wr_sel = '0; ptr_wr_op = '0; ptr_wr_data = '0;
  endtask

  // R2: both ports read independently, swept over every index
  task automatic sweep(input string req);
    for (int i = 0; i < NR; i++) begin
      rd_a_idx = IW'(i);
      rd_b_idx = IW'(NR - 1 - i);
      #1;
      chk({req, " portA"}, 32'(rd_a_data), 32'(mdl[i]));
      chk({req, " portB R2"}, 32'(rd_b_data), 32'(mdl[NR-1-i]));
    end
  endtask

  // R5: pointer read of every code
  task automatic ptr_sweep(input string req);
    for (int s = 0; s < 4; s++) begin
      ptr_rd_sel = 2'(s);
      #1;
      chk({req, " ptr R5"}, 32'(ptr_rd_data), 32'(mdl_ptr(s)));
    end
  endtask

  task automatic cycle(input logic en, input int idx, input logic [7:0] d,
                       input int psel, input int pop, input logic [15:0] pd);
    logic [15:0] cur, nv;
    int lo;
    @(negedge clk);
    wr_en = en; wr_idx = IW'(idx); wr_data = d;
    ptr_wr_sel = 2'(psel); ptr_wr_op = 2'(pop); ptr_wr_data = pd;
    rd_a_idx = IW'(idx);
    ptr_rd_sel = 2'(psel);
    #0.5;
    // R4: old values before the edge, no bypass
    chk("R4 read during write", 32'(rd_a_data), 32'(mdl[idx]));
    chk("R4 ptr read during write", 32'(ptr_rd_data), 32'(mdl_ptr(psel)));
    @(posedge clk);
    #1;
    cur = mdl_ptr(psel);
    case (pop)
      1: nv = pd;
      2: nv = cur + 16'd1;
      3: nv = cur - 16'd1;
      default: nv = cur;
    endcase
    if (en) mdl[idx] = d;
    if (psel != 0 && pop != 0) begin
      lo = NR - 8 + 2 * psel;
      mdl[lo]   = nv[7:0];
      mdl[lo+1] = nv[15:8];
    end
    idle();
  endtask

  task automatic ptr_expect(input string req, input int sel, input logic [15:0] exp);
    ptr_rd_sel = 2'(sel);
    #0.5;
    chk(req, 32'(ptr_rd_data), 32'(exp));
  endtask

  initial begin
    int lcg;
    idle();
    for (int i = 0; i < NR; i++) mdl[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    sweep("R1 reset");
    ptr_sweep("R1 reset");

    // R3: fill every register
    for (int i = 0; i < NR; i++) cycle(1'b1, i, 8'((i * 37 + 11) & 255), 0, 0, 16'h0);
    sweep("R3 fill");
    ptr_sweep("R10 byte-to-pointer");

    // R6 / R7 carry and borrow corners on each pair
    for (int s = 1; s < 4; s++) begin
      cycle(1'b0, 0, 8'h0, s, 1, 16'h00FF);
      ptr_expect("R6 load", s, 16'h00FF);
      cycle(1'b0, 0, 8'h0, s, 2, 16'h0);
      ptr_expect("R7 inc carry", s, 16'h0100);
      rd_a_idx = IW'(NR - 7 + 2 * s);
      #0.5;
      chk("R10 high byte via port", 32'(rd_a_data), 32'h01);
      cycle(1'b0, 0, 8'h0, s, 3, 16'h0);
      ptr_expect("R7 dec borrow", s, 16'h00FF);
      cycle(1'b0, 0, 8'h0, s, 1, 16'hFFFF);
      cycle(1'b0, 0, 8'h0, s, 2, 16'h1234);
      ptr_expect("R7 inc wrap", s, 16'h0000);
      cycle(1'b0, 0, 8'h0, s, 3, 16'h1234);
      ptr_expect("R7 dec wrap", s, 16'hFFFF);
    end
    sweep("R6 after pointer ops");

    // R8: select 0 or op 0 do nothing
    cycle(1'b0, 3, 8'hAA, 0, 1, 16'h1234);
    sweep("R8 sel none");
    ptr_sweep("R8 sel none");
    cycle(1'b0, 3, 8'hAA, 1, 0, 16'hABCD);
    sweep("R8 op none");
    ptr_sweep("R8 op none");

    // R9: conflicts
    cycle(1'b1, 26, 8'h55, 1, 1, 16'hBEEF);
    ptr_expect("R9 ptr wins low", 1, 16'hBEEF);
    cycle(1'b1, 31, 8'h66, 3, 2, 16'h0);
    ptr_expect("R9 ptr wins high", 3, 16'h0000);
    cycle(1'b1, 5, 8'h77, 2, 1, 16'h1357);
    ptr_expect("R9 other pair", 2, 16'h1357);
    rd_a_idx = IW'(5);
    #0.5;
    chk("R9 byte elsewhere", 32'(rd_a_data), 32'h77);
    sweep("R9 after conflicts");

    // mixed traffic
    lcg = 32'h1F2E3D4C;
    for (int n = 0; n < 300; n++) begin
      logic [31:0] r;
      lcg = lcg * 1103515245 + 12345;
      r = 32'(lcg);
      cycle(r[0], int'(r[5:1]), r[13:6], int'(r[15:14]), int'(r[17:16]), r[31:16]);
      if (n % 10 == 0) begin
        sweep("R3 mixed");
        ptr_sweep("R10 mixed");
      end
    end
    sweep("R3 final");
    ptr_sweep("R5 final");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule